// File: doc/BRIEF.md
# Qualified Programmable Event Counter

A single programmable performance-monitoring counter. Every clock cycle it sees a vector of sub-event strobes grouped by event code, plus the privilege ring the observed thread is running at. A control register selects one event code and a mask of its sub-events. A qualifier chain then decides how much to add this cycle. The chain consists of a count threshold, an optional inversion of that comparison, rising-edge-only counting and ring filtering.

Software reaches the control, counter and status registers through a small synchronous register port. When the 48-bit count carries out of its top bit with interrupts enabled, a sticky status flag is set and drives the interrupt request. It stays set until software clears it.

Top module: `perf_event_counter`

## Requirements
- R1: After reset the control register, counter and status flag read as zero and `irq_o` is low.
- R2: The per-cycle event sum is the number of set bits in `ev_i[code*8 +: 8] & mask`, where code is control bits [7:0] and mask is control bits [15:8]. A code of NUM_CODES or above gives a sum of zero. With the threshold (control bits [23:16]) at zero, the counter adds the full sum each enabled cycle.
- R3: With a nonzero threshold, the counter adds exactly one in a cycle whose sum is greater than or equal to the threshold, and zero otherwise.
- R4: With a nonzero threshold and the invert bit (control bit 25) set, the counter adds one in cycles whose sum is below the threshold.
- R5: With a nonzero threshold and the edge bit (control bit 24) set, the counter adds one only in a cycle where the qualified condition is true and was false in the previous cycle.
- R6: Ring 0 (`priv_i` = 0) is counted when the kernel bit (control bit 26) is set. Rings 1 to 3 are counted when the user bit (control bit 27) is set. With both bits clear, every ring is counted. A filtered cycle counts as a false condition.
- R7: With the enable bit (control bit 29) clear, the counter does not change except by a software write.
- R8: Register addresses are 0 for control, 1 for counter and 2 for status; address 3 reads as zero. `rdata_o` returns, one cycle after the address is presented, the register value from before that clock edge. A counter write in the same cycle as an increment loads the written value.
- R9: An increment that carries out of bit 47 wraps the counter modulo 2^48. It sets the status flag (status bit 0, also `irq_o`) only if the interrupt-enable bit (control bit 28) is set.
- R10: The status flag stays set until a write to address 2 with data bit 0 set. A new overflow in the same cycle wins over the clear.
- R11: Any control write, and any disabled cycle, clears the remembered previous condition. As a result, the first true cycle afterwards counts as a rising edge.
- R12: With the threshold at zero, the edge and invert bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ev_i | input | NUM_CODES*8 | Sub-event strobes, 8 per event code |
| priv_i | input | 2 | Current privilege ring |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Register write enable |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench attacks the threshold boundary, where the sum equals the threshold exactly. A wrong comparison operator would count or skip exactly those cycles, or would invert them wrongly under the invert bit. Edge mode is run both with a condition held true across a reprogramming write and with sparse toggling. A detector that is not cleared on reprogramming would miss the first edge, and one that is not registered would count every true cycle.

The bench drives a counter value just below the 48-bit wrap so that it crosses the top with and without interrupt enable. It also writes the counter while events fire. These runs expose a wrong carry, a flag set without enable, a lost sticky bit, or an increment winning over the write. The privilege runs cover each of the four kernel/user bit combinations across all rings.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;
  localparam int UMASK_W = 8;
  localparam int CODE_W  = 8;
  localparam int THR_W   = 8;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_CNT  = 1;
  localparam int ADDR_STAT = 2;

  typedef struct packed {
    logic               enable;
    logic               irq_en;
    logic               usr_en;
    logic               os_en;
    logic               inv;
    logic               edge_en;
    logic [THR_W-1:0]   cmask;
    logic [UMASK_W-1:0] umask;
    logic [CODE_W-1:0]  evsel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/event_sum.sv
module event_sum import perf_cnt_pkg::*; #(
  parameter int NUM_CODES = 4,
  localparam int SUM_W = $clog2(UMASK_W + 1)
) (
  input  logic [NUM_CODES*UMASK_W-1:0] ev_i,
  input  logic [CODE_W-1:0]            evsel_i,
  input  logic [UMASK_W-1:0]           umask_i,
  output logic [SUM_W-1:0]             sum_o
);
  localparam int IDX_W = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1;

  logic [UMASK_W-1:0] lane [NUM_CODES];
  logic [UMASK_W-1:0] picked;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_lane
    assign lane[g] = ev_i[g*UMASK_W +: UMASK_W];
  end

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_CODES; i++)
      if (32'(evsel_i) == i) picked = lane[i];
  end

  logic [IDX_W-1:0] unused_idx;
  assign unused_idx = '0;

  always_comb begin
    sum_o = '0;
    for (int b = 0; b < UMASK_W; b++)
      sum_o = sum_o + SUM_W'(picked[b] & umask_i[b]);
  end

  always_comb begin
    assert_sum_bound_R2: assert (32'(sum_o) <= UMASK_W);
  end
endmodule

// File: rtl/qual_chain.sv
module qual_chain import perf_cnt_pkg::*; #(
  localparam int SUM_W = $clog2(UMASK_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic [SUM_W-1:0] sum_i,
  input  logic [1:0]       priv_i,
  input  logic             clr_i,
  output logic [SUM_W-1:0] inc_o
);
  logic priv_ok, above, hit, prev_q;

  always_comb begin
    if (!ctrl_i.os_en && !ctrl_i.usr_en) priv_ok = 1'b1;
    else if (priv_i == 2'd0)             priv_ok = ctrl_i.os_en;
    else                                 priv_ok = ctrl_i.usr_en;
    above = THR_W'(sum_i) >= ctrl_i.cmask;
    hit   = priv_ok && (ctrl_i.inv ? !above : above);
  end

  always_comb begin
    inc_o = '0;
    if (ctrl_i.enable) begin
      if (ctrl_i.cmask == '0)
        inc_o = priv_ok ? sum_i : '0;
      else if (ctrl_i.edge_en ? (hit && !prev_q) : hit)
        inc_o = SUM_W'(1);
    end
  end

  // previous-condition register for edge mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         prev_q <= 1'b0;
    else if (clr_i || !ctrl_i.enable)    prev_q <= 1'b0;
    else                                 prev_q <= hit;
  end

  assert_thr_unit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.cmask != '0) |-> (inc_o <= SUM_W'(1)));

  assert_edge_once_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.enable && ctrl_i.edge_en && ctrl_i.cmask != '0 && inc_o != '0 && !clr_i)
    |=> (inc_o == '0));

  assert_ring_filter_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.os_en != ctrl_i.usr_en && ((priv_i == 2'd0) != ctrl_i.os_en)) |-> (inc_o == '0));
endmodule

// File: rtl/cnt_core.sv
module cnt_core #(
  parameter int CNT_W = 48,
  parameter int INC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             irq_en_i,
  input  logic             stat_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, nxt;
  logic             carry, ovf_q;

  assign {carry, nxt} = {1'b0, cnt_q} + (CNT_W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (wr_i) cnt_q <= wdata_i;
    else           cnt_q <= nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ovf_q <= 1'b0;
    else if (!wr_i && carry && irq_en_i)  ovf_q <= 1'b1;
    else if (stat_clr_i)                  ovf_q <= 1'b0;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  assert_wr_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == $past(wdata_i)));

  assert_ovf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !stat_clr_i) |=> ovf_q);

  assert_ovf_needs_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(irq_en_i));
endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter import perf_cnt_pkg::*; #(
  parameter int NUM_CODES = 4,
  parameter int CNT_W     = 48,
  parameter int DATA_W    = 48,
  parameter int ADDR_W    = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_CODES*UMASK_W-1:0] ev_i,
  input  logic [1:0]                   priv_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic                         we_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic                         irq_o
);
  localparam int SUM_W = $clog2(UMASK_W + 1);

  ctrl_t             ctrl_q;
  logic [SUM_W-1:0]  sum, inc;
  logic [CNT_W-1:0]  cnt;
  logic              ovf;
  logic              ctrl_wr, cnt_wr, stat_clr;
  logic [DATA_W-1:0] rdata_q;

  assign ctrl_wr  = we_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign cnt_wr   = we_i && (addr_i == ADDR_W'(ADDR_CNT));
  assign stat_clr = we_i && (addr_i == ADDR_W'(ADDR_STAT)) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  event_sum #(.NUM_CODES(NUM_CODES)) u_sum (
    .ev_i    (ev_i),
    .evsel_i (ctrl_q.evsel),
    .umask_i (ctrl_q.umask),
    .sum_o   (sum)
  );

  qual_chain u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctrl_i (ctrl_q),
    .sum_i  (sum),
    .priv_i (priv_i),
    .clr_i  (ctrl_wr),
    .inc_o  (inc)
  );

  cnt_core #(.CNT_W(CNT_W), .INC_W(SUM_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (inc),
    .wr_i       (cnt_wr),
    .wdata_i    (wdata_i[CNT_W-1:0]),
    .irq_en_i   (ctrl_q.irq_en),
    .stat_clr_i (stat_clr),
    .cnt_o      (cnt),
    .ovf_o      (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else begin
      case (32'(addr_i))
        ADDR_CTRL: rdata_q <= DATA_W'(ctrl_q);
        ADDR_CNT:  rdata_q <= DATA_W'(cnt);
        ADDR_STAT: rdata_q <= DATA_W'(ovf);
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = ovf;

  assert_hold_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.enable && !cnt_wr) |=> $stable(cnt));

  assert_irq_follows_stat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(ADDR_STAT)) |=> (rdata_o[0] == $past(irq_o)));
endmodule

// File: tb/perf_event_counter_tb.sv
module perf_event_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int EW = NC * 8;
  localparam logic [48:0] WRAP = 49'h1_0000_0000_0000;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [EW-1:0] ev = '0;
  logic [1:0]    priv = '0;
  logic [1:0]    addr = 2'd1;
  logic          we = 0;
  logic [47:0]   wdata = '0;
  logic [47:0]   rdata;
  logic          irq;

  int total = 0, bad = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_event_counter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ev_i(ev), .priv_i(priv),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  logic [29:0] m_ctrl;
  logic [47:0] m_cnt, exp_rd;
  logic        m_ovf, m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0; m_cnt = '0; m_ovf = 0; m_prev = 0; exp_rd = '0;
    end else begin
      int code, n, thr, add;
      bit pok, q, carry;
      logic [48:0] s;
      case (addr)
        2'd0: exp_rd = 48'(m_ctrl);
        2'd1: exp_rd = m_cnt;
        2'd2: exp_rd = 48'(m_ovf);
        default: exp_rd = '0;
      endcase
      code = int'(m_ctrl[7:0]);
      n = 0;
      if (code < NC)
        for (int b = 0; b < 8; b++) n += (ev[code*8+b] & m_ctrl[8+b]) ? 1 : 0;
      thr = int'(m_ctrl[23:16]);
      if (!m_ctrl[26] && !m_ctrl[27]) pok = 1;
      else pok = (priv == 0) ? m_ctrl[26] : m_ctrl[27];
      q = pok && (m_ctrl[25] ? (n < thr) : (n >= thr));
      add = 0;
      if (m_ctrl[29]) begin
        if (thr == 0) add = pok ? n : 0;
        else if (m_ctrl[24]) add = (q && !m_prev) ? 1 : 0;
        else add = q ? 1 : 0;
      end
      m_prev = (!m_ctrl[29] || (we && addr == 0)) ? 1'b0 : q;
      carry = 0;
      if (we && addr == 1) m_cnt = wdata;
      else begin
        s = {1'b0, m_cnt} + 49'(add);
        carry = s >= WRAP;
        m_cnt = s[47:0];
      end
      if (carry && m_ctrl[28]) m_ovf = 1;
      else if (we && addr == 2 && wdata[0]) m_ovf = 0;
      if (we && addr == 0) m_ctrl = wdata[29:0];
    end
  end

  task automatic chk(string req, logic [47:0] act, logic [47:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, rdata, exp_rd);
      chk(cur_req, 48'(irq), 48'(m_ovf));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [47:0] d);
    addr = a; we = 1; wdata = d;
    tick(1);
    we = 0; addr = 2'd1;
  endtask

  task automatic run_rand(int n, bit sparse, bit rand_priv);
    for (int i = 0; i < n; i++) begin
      ev = sparse ? EW'($urandom & $urandom & $urandom) : EW'($urandom);
      if (rand_priv) priv = 2'($urandom);
      tick(1);
    end
  endtask

  function automatic logic [47:0] cfg(bit en, bit ie, bit usr, bit os, bit inv,
                                      bit edg, int thr, int um, int code);
    return 48'({en, ie, usr, os, inv, edg, 8'(thr), 8'(um), 8'(code)});
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    // R1 reset values
    cur_req = "R1";
    addr = 2'd0; tick(1); chk("R1 ctrl", rdata, '0);
    addr = 2'd1; tick(1); chk("R1 cnt", rdata, '0);
    addr = 2'd2; tick(1); chk("R1 stat", rdata, '0); chk("R1 irq", 48'(irq), '0);
    addr = 2'd1;

    cur_req = "R2";
    wr(0, cfg(1,0,1,1,0,0,0,8'hFF,1)); run_rand(40, 0, 1);
    wr(0, cfg(1,0,1,1,0,0,0,8'h0F,2)); run_rand(40, 0, 1);
    wr(0, cfg(1,0,1,1,0,0,0,8'hFF,5)); run_rand(20, 0, 1);
    addr = 2'd3; tick(2); addr = 2'd0; tick(2); addr = 2'd1;

    cur_req = "R3";
    wr(0, cfg(1,0,0,0,0,0,3,8'hFF,0)); run_rand(60, 0, 1);
    wr(0, cfg(1,0,0,0,0,0,8,8'hFF,3)); run_rand(40, 0, 1);

    cur_req = "R4";
    wr(0, cfg(1,0,0,0,1,0,3,8'hFF,0)); run_rand(60, 0, 1);

    cur_req = "R5";
    wr(0, cfg(1,0,0,0,0,1,1,8'h0F,1)); run_rand(80, 1, 0);
    wr(0, cfg(1,0,0,0,1,1,2,8'hFF,2)); run_rand(60, 0, 0);

    cur_req = "R6";
    wr(0, cfg(1,0,0,1,0,0,0,8'hFF,0)); run_rand(40, 0, 1);
    wr(0, cfg(1,0,1,0,0,0,0,8'hFF,0)); run_rand(40, 0, 1);
    wr(0, cfg(1,0,1,0,0,0,2,8'hFF,0)); run_rand(40, 0, 1);

    cur_req = "R7";
    wr(0, cfg(0,0,1,1,0,0,0,8'hFF,0)); run_rand(40, 0, 1);

    cur_req = "R8";
    wr(0, cfg(1,0,1,1,0,0,0,8'hFF,0));
    ev = '1; wr(1, 48'd100); tick(3);
    wr(1, 48'h1234_5678_9ABC); tick(2);

    cur_req = "R9";
    wr(0, cfg(1,1,1,1,0,0,0,8'hFF,0));
    ev = '1; wr(1, 48'hFFFF_FFFF_FFFD); tick(3);
    cur_req = "R10";
    ev = '0; tick(3);
    wr(2, 48'd1); tick(3);
    cur_req = "R9";
    wr(0, cfg(1,0,1,1,0,0,0,8'hFF,0));
    ev = '1; wr(1, 48'hFFFF_FFFF_FFFE); tick(3);
    cur_req = "R10";
    wr(0, cfg(1,1,1,1,0,0,0,8'hFF,0));
    wr(1, 48'hFFFF_FFFF_FFFF); wr(2, 48'd0); tick(2);
    wr(1, 48'hFFFF_FFFF_FFFC);
    addr = 2'd2; we = 1; wdata = 48'd1; tick(1); we = 0; addr = 2'd1; tick(2);
    wr(2, 48'd1); tick(2);

    cur_req = "R11";
    ev = '1;
    wr(0, cfg(1,0,1,1,0,1,2,8'hFF,0)); tick(5);
    wr(0, cfg(1,0,1,1,0,1,2,8'hFF,0)); tick(5);
    wr(0, cfg(0,0,1,1,0,1,2,8'hFF,0)); tick(2);
    wr(0, cfg(1,0,1,1,0,1,2,8'hFF,0)); tick(4);

    cur_req = "R12";
    wr(0, cfg(1,0,1,1,1,1,0,8'hFF,3)); run_rand(40, 0, 1);

    tick(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule